// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

A shared peripheral for a small multiprocessor system. Each processor has its own register port and its own interrupt line, and every processor maps that line to the same interrupt number. One processor can interrupt another and hand it a data word. The operating system uses this for scheduling messages.

A sender first writes the word into its staging register. It then writes the target's index to its send register. That word lands in the target's receive mailbox along with the sender's index, and the target's interrupt goes high. The interrupt stays high until the target reads the word and writes its acknowledge register. The mailbox holds one message. A send to a full mailbox is refused, and the sender sees a busy flag until it can retry. When several ports send to the same target in one cycle, the lowest-numbered port wins. Sending to oneself is allowed.

Per-port register offsets:

| Offset | Access | Meaning |
|---|---|---|
| 0 | write | send, target index in bits [7:0] |
| 1 | write | stage data word |
| 2 | read | received data word |
| 3 | read | status: bit 0 pending, bit 1 busy, bits [15:8] sender index |
| 4 | write | acknowledge |

Top module: `ipi_mailbox`

## Requirements
- R1: While reset is asserted and after it, every irq_o bit is 0, and offsets 2 and 3 read 0 on every port.
- R2: A write to offset 0 on port s with bits [7:0] equal to t (t < N_PORTS) copies the word staged by s (offset 1) into t's mailbox, readable at offset 2 of port t. The write also sets status bit 0 and puts s in status bits [15:8]. irq_o[t] is high from the cycle after the write.
- R3: irq_o[t] and status bit 0 stay high until port t writes offset 4. Other writes from any port, such as a new staging word, do not clear them.
- R4: A write to offset 4 on port t clears its pending bit, so irq_o[t] is low from the next cycle. The same write while nothing is pending changes nothing.
- R5: A send to a target whose mailbox is pending is dropped. The target's data and sender index are unchanged, and the sender's status bit 1 (busy) is set.
- R6: A sender's busy bit clears when the refusing target writes offset 4, or when the sender makes a successful send. If a refusal and that target's acknowledge fall in the same cycle, busy is set.
- R7: When several ports send to the same free target in one cycle, the lowest-numbered port is delivered and each other sender gets busy.
- R8: A port may send to itself, with the same effect as any other send.
- R9: A send whose target field is N_PORTS or more is ignored. It raises no interrupt, sets no busy bit and changes no mailbox.
- R10: Offsets 0, 1 and 4 read as 0, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_en_i | input | N_PORTS | per-port write strobe |
| addr_i | input | N_PORTS*ADDR_W | per-port register offset, port p at [p*ADDR_W +: ADDR_W] |
| wdata_i | input | N_PORTS*DATA_W | per-port write data |
| rdata_o | output | N_PORTS*DATA_W | per-port read data for the offset on addr_i (combinational) |
| irq_o | output | N_PORTS | per-processor interrupt level |

## Verification
The checker tests these properties on every cycle:
- an interrupt rises only after a send addressed to that target;
- an interrupt holds until that target acknowledges;
- an acknowledge of a pending mailbox drops the interrupt in the next cycle;
- a pending mailbox's data word never changes before it is acknowledged.

Some behaviour needs a chosen sequence of stimulus, so only the bench scenarios show it:
- the value delivered;
- the status encoding;
- lowest-port arbitration and the busy flags of the losers;
- busy clearing by acknowledge or by a retry;
- the coincident refuse-and-acknowledge case;
- self-sends;
- out-of-range targets.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  localparam int ID_W        = 8;
  localparam int OFF_SEND    = 0;
  localparam int OFF_STAGE   = 1;
  localparam int OFF_RX      = 2;
  localparam int OFF_STATUS  = 3;
  localparam int OFF_ACK     = 4;
  localparam int ST_PEND_BIT = 0;
  localparam int ST_BUSY_BIT = 1;
  localparam int ST_SRC_LSB  = 8;
endpackage

// File: rtl/ipi_port_decode.sv
`timescale 1ns/1ps
module ipi_port_decode
  import ipi_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 3
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ID_W-1:0]   tgt_i,
  output logic              send_o,
  output logic              stage_we_o,
  output logic              ack_o
);
  logic tgt_ok;

  assign tgt_ok     = int'(tgt_i) < N_PORTS;
  assign send_o     = wr_en_i && (addr_i == ADDR_W'(OFF_SEND)) && tgt_ok;
  assign stage_we_o = wr_en_i && (addr_i == ADDR_W'(OFF_STAGE));
  assign ack_o      = wr_en_i && (addr_i == ADDR_W'(OFF_ACK));
endmodule

// File: rtl/ipi_arbiter.sv
`timescale 1ns/1ps
module ipi_arbiter
  import ipi_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int PW      = 2
) (
  input  logic [N_PORTS-1:0]      req_i,
  input  logic [N_PORTS*ID_W-1:0] tgt_i,
  input  logic [N_PORTS-1:0]      pending_i,
  output logic [N_PORTS-1:0]      deliver_o,
  output logic [N_PORTS*PW-1:0]   src_o,
  output logic [N_PORTS-1:0]      accept_o,
  output logic [N_PORTS-1:0]      reject_o,
  output logic [N_PORTS*PW-1:0]   tidx_o
);
  logic [N_PORTS-1:0] found;

  // per target: lowest requesting port wins, delivered only into an empty box
  always_comb begin
    found     = '0;
    deliver_o = '0;
    src_o     = '0;
    for (int t = 0; t < N_PORTS; t++) begin
      for (int p = 0; p < N_PORTS; p++) begin
        if (req_i[p] && tgt_i[p*ID_W +: ID_W] == ID_W'(t) && !found[t]) begin
          found[t]          = 1'b1;
          src_o[t*PW +: PW] = PW'(p);
        end
      end
      deliver_o[t] = found[t] && !pending_i[t];
    end
  end

  always_comb begin
    accept_o = '0;
    reject_o = '0;
    tidx_o   = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      for (int t = 0; t < N_PORTS; t++) begin
        if (req_i[p] && tgt_i[p*ID_W +: ID_W] == ID_W'(t)) begin
          tidx_o[p*PW +: PW] = PW'(t);
          if (deliver_o[t] && src_o[t*PW +: PW] == PW'(p)) accept_o[p] = 1'b1;
        end
      end
      reject_o[p] = req_i[p] && !accept_o[p];
    end
  end
endmodule

// File: rtl/ipi_mbox_bank.sv
`timescale 1ns/1ps
module ipi_mbox_bank
  import ipi_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int PW      = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS-1:0]        stage_we_i,
  input  logic [N_PORTS*DATA_W-1:0] wdata_i,
  input  logic [N_PORTS-1:0]        ack_i,
  input  logic [N_PORTS-1:0]        deliver_i,
  input  logic [N_PORTS*PW-1:0]     src_i,
  input  logic [N_PORTS-1:0]        accept_i,
  input  logic [N_PORTS-1:0]        reject_i,
  input  logic [N_PORTS*PW-1:0]     tidx_i,
  input  logic [N_PORTS*ADDR_W-1:0] addr_i,
  output logic [N_PORTS-1:0]        pending_o,
  output logic [N_PORTS*DATA_W-1:0] rx_data_o,
  output logic [N_PORTS*DATA_W-1:0] rdata_o
);
  logic [N_PORTS*DATA_W-1:0] stage_flat;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] rx_q;
    logic [PW-1:0]     src_q;
    logic [PW-1:0]     btgt_q;
    logic              pend_q;
    logic              busy_q;
    logic [DATA_W-1:0] status;
    logic [PW-1:0]     my_src;

    assign my_src = src_i[g*PW +: PW];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            stage_q <= '0;
      else if (stage_we_i[g]) stage_q <= wdata_i[g*DATA_W +: DATA_W];
    end

    // receive side; deliver only happens when not pending
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_q   <= '0;
        src_q  <= '0;
        pend_q <= 1'b0;
      end else if (deliver_i[g]) begin
        rx_q   <= stage_flat[int'(my_src)*DATA_W +: DATA_W];
        src_q  <= my_src;
        pend_q <= 1'b1;
      end else if (ack_i[g]) begin
        pend_q <= 1'b0;
      end
    end

    // send side busy flag; refusal has priority over clearing
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        btgt_q <= '0;
      end else if (reject_i[g]) begin
        busy_q <= 1'b1;
        btgt_q <= tidx_i[g*PW +: PW];
      end else if (accept_i[g]) begin
        busy_q <= 1'b0;
      end else if (busy_q && ack_i[btgt_q]) begin
        busy_q <= 1'b0;
      end
    end

    always_comb begin
      status                       = '0;
      status[ST_PEND_BIT]          = pend_q;
      status[ST_BUSY_BIT]          = busy_q;
      status[ST_SRC_LSB +: PW]     = src_q;
    end

    always_comb begin
      unique case (addr_i[g*ADDR_W +: ADDR_W])
        ADDR_W'(OFF_RX):     rdata_o[g*DATA_W +: DATA_W] = rx_q;
        ADDR_W'(OFF_STATUS): rdata_o[g*DATA_W +: DATA_W] = status;
        default:             rdata_o[g*DATA_W +: DATA_W] = '0;
      endcase
    end

    assign stage_flat[g*DATA_W +: DATA_W] = stage_q;
    assign rx_data_o[g*DATA_W +: DATA_W]  = rx_q;
    assign pending_o[g]                   = pend_q;
  end
endmodule

// File: rtl/ipi_mailbox.sv
`timescale 1ns/1ps
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS-1:0]        wr_en_i,
  input  logic [N_PORTS*ADDR_W-1:0] addr_i,
  input  logic [N_PORTS*DATA_W-1:0] wdata_i,
  output logic [N_PORTS*DATA_W-1:0] rdata_o,
  output logic [N_PORTS-1:0]        irq_o
);
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [N_PORTS-1:0]        send;
  logic [N_PORTS-1:0]        stage_we;
  logic [N_PORTS-1:0]        ack;
  logic [N_PORTS*ID_W-1:0]   tgt;
  logic [N_PORTS-1:0]        deliver;
  logic [N_PORTS*PW-1:0]     src_sel;
  logic [N_PORTS-1:0]        accept;
  logic [N_PORTS-1:0]        reject;
  logic [N_PORTS*PW-1:0]     tidx;
  logic [N_PORTS-1:0]        pending;
  logic [N_PORTS*DATA_W-1:0] rx_data_q;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_dec
    assign tgt[g*ID_W +: ID_W] = wdata_i[g*DATA_W +: ID_W];
    ipi_port_decode #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_dec (
      .wr_en_i    (wr_en_i[g]),
      .addr_i     (addr_i[g*ADDR_W +: ADDR_W]),
      .tgt_i      (tgt[g*ID_W +: ID_W]),
      .send_o     (send[g]),
      .stage_we_o (stage_we[g]),
      .ack_o      (ack[g])
    );
  end

  ipi_arbiter #(.N_PORTS(N_PORTS), .PW(PW)) u_arb (
    .req_i     (send),
    .tgt_i     (tgt),
    .pending_i (pending),
    .deliver_o (deliver),
    .src_o     (src_sel),
    .accept_o  (accept),
    .reject_o  (reject),
    .tidx_o    (tidx)
  );

  ipi_mbox_bank #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PW(PW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stage_we_i (stage_we),
    .wdata_i    (wdata_i),
    .ack_i      (ack),
    .deliver_i  (deliver),
    .src_i      (src_sel),
    .accept_i   (accept),
    .reject_i   (reject),
    .tidx_i     (tidx),
    .addr_i     (addr_i),
    .pending_o  (pending),
    .rx_data_o  (rx_data_q),
    .rdata_o    (rdata_o)
  );

  assign irq_o = pending;
endmodule

// File: rtl/ipi_mailbox_chk.sv
`timescale 1ns/1ps
module ipi_mailbox_chk
  import ipi_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_PORTS-1:0]        wr_en_i,
  input logic [N_PORTS*ADDR_W-1:0] addr_i,
  input logic [N_PORTS*DATA_W-1:0] wdata_i,
  input logic [N_PORTS-1:0]        irq_o,
  input logic [N_PORTS*DATA_W-1:0] rx_data_i
);
  logic [N_PORTS-1:0] hit;
  logic [N_PORTS-1:0] ack_hit;

  always_comb begin
    hit     = '0;
    ack_hit = '0;
    for (int t = 0; t < N_PORTS; t++) begin
      ack_hit[t] = wr_en_i[t] && addr_i[t*ADDR_W +: ADDR_W] == ADDR_W'(OFF_ACK);
      for (int p = 0; p < N_PORTS; p++)
        if (wr_en_i[p] && addr_i[p*ADDR_W +: ADDR_W] == ADDR_W'(OFF_SEND) &&
            wdata_i[p*DATA_W +: ID_W] == ID_W'(t))
          hit[t] = 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> irq_o == '0);

  for (genvar t = 0; t < N_PORTS; t++) begin : g_t
    a_r2_rise_needs_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[t]) |-> $past(hit[t]));
    a_r3_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] && !ack_hit[t] |=> irq_o[t]);
    a_r4_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] && ack_hit[t] |=> !irq_o[t]);
    a_r5_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] && !ack_hit[t] |=> $stable(rx_data_i[t*DATA_W +: DATA_W]));
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .rx_data_i (rx_data_q)
);

// File: tb/sim_ipi_mailbox.sv
`timescale 1ns/1ps
module sim_ipi_mailbox;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [NP-1:0]    wr = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*DW-1:0] wdata = '0;
  logic [NP*DW-1:0] rdata;
  logic [NP-1:0]    irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipi_mailbox #(.N_PORTS(NP), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit          m_pend[NP];
  bit          m_busy[NP];
  int          m_btgt[NP];
  int          m_src[NP];
  logic [31:0] m_rx[NP];
  logic [31:0] m_stg[NP];

  function automatic int a_of(int p); return int'(addr[p*AW +: AW]); endfunction
  function automatic logic [31:0] d_of(int p); return wdata[p*DW +: DW]; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_pend[i] = 0; m_busy[i] = 0; m_btgt[i] = 0; m_src[i] = 0;
        m_rx[i] = '0; m_stg[i] = '0;
      end
    end else begin
      bit taken[NP];
      bit old_pend[NP];
      bit touched[NP];
      logic [31:0] old_stg[NP];
      for (int i = 0; i < NP; i++) begin
        taken[i] = 0; touched[i] = 0; old_pend[i] = m_pend[i]; old_stg[i] = m_stg[i];
      end
      for (int p = 0; p < NP; p++) begin
        if (wr[p] && a_of(p) == 0 && int'(d_of(p)[7:0]) < NP) begin
          int t;
          t = int'(d_of(p)[7:0]);
          touched[p] = 1;
          if (!old_pend[t] && !taken[t]) begin
            taken[t] = 1; m_pend[t] = 1; m_rx[t] = old_stg[p]; m_src[t] = p; m_busy[p] = 0;
          end else begin
            m_busy[p] = 1; m_btgt[p] = t;
          end
        end
      end
      for (int t = 0; t < NP; t++)
        if (wr[t] && a_of(t) == 4 && old_pend[t]) m_pend[t] = 0;
      for (int p = 0; p < NP; p++)
        if (!touched[p] && m_busy[p] && wr[m_btgt[p]] && a_of(m_btgt[p]) == 4) m_busy[p] = 0;
      for (int p = 0; p < NP; p++)
        if (wr[p] && a_of(p) == 1) m_stg[p] = d_of(p);
    end
  end

  function automatic logic [31:0] exp_rd(int p);
    case (a_of(p))
      2: return m_rx[p];
      3: return (32'(m_src[p]) << 8) | (32'(m_busy[p]) << 1) | 32'(m_pend[p]);
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      for (int p = 0; p < NP; p++) begin
        chk("R2 model irq", 32'(irq[p]), 32'(m_pend[p]));
        chk("R2 model rdata", rdata[p*DW +: DW], exp_rd(p));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog all got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk); wr = '0;
  endtask

  task automatic wr1(int p, int off, logic [31:0] d);
    @(negedge clk);
    wr = '0; wr[p] = 1'b1;
    addr[p*AW +: AW] = AW'(off); wdata[p*DW +: DW] = d;
  endtask

  task automatic wr2(int p, int po, logic [31:0] pd, int q, int qo, logic [31:0] qd);
    @(negedge clk);
    wr = '0; wr[p] = 1'b1; wr[q] = 1'b1;
    addr[p*AW +: AW] = AW'(po); wdata[p*DW +: DW] = pd;
    addr[q*AW +: AW] = AW'(qo); wdata[q*DW +: DW] = qd;
  endtask

  task automatic rd(int p, int off, logic [31:0] exp, string tag);
    @(negedge clk);
    wr = '0; addr[p*AW +: AW] = AW'(off);
    #1; chk(tag, rdata[p*DW +: DW], exp);
  endtask

  task automatic irq_is(logic [NP-1:0] exp, string tag);
    @(negedge clk); wr = '0;
    #1; chk(tag, 32'(irq), 32'(exp));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R1: reset state
    #0.5 chk("R1 irq in reset", 32'(irq), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(0, 3, 32'h0, "R1 status after reset");
    rd(1, 2, 32'h0, "R1 rx after reset");
    irq_is(4'b0000, "R1 irq after reset");

    // R2: port 0 to port 2
    wr1(0, 1, 32'hA5A5_0001);
    wr1(0, 0, 32'h0000_0002);
    irq_is(4'b0100, "R2 irq target");
    rd(2, 2, 32'hA5A5_0001, "R2 rx data");
    rd(2, 3, 32'h0000_0001, "R2 status sender0 pending");

    // R3: holds across idle and unrelated writes
    repeat (4) idle();
    wr1(2, 1, 32'h0000_BEEF);
    irq_is(4'b0100, "R3 irq still high");
    rd(2, 3, 32'h0000_0001, "R3 pending kept");

    // R5: send to full box
    wr1(1, 1, 32'h0000_1111);
    wr1(1, 0, 32'h0000_0002);
    rd(2, 2, 32'hA5A5_0001, "R5 rx unchanged");
    rd(2, 3, 32'h0000_0001, "R5 sender unchanged");
    rd(1, 3, 32'h0000_0002, "R5 sender busy");

    // R4 and R6: ack clears pending and sender busy
    wr1(2, 4, 32'h0);
    irq_is(4'b0000, "R4 irq low after ack");
    rd(1, 3, 32'h0000_0000, "R6 busy cleared by ack");
    wr1(2, 4, 32'h0);
    rd(2, 3, 32'h0000_0000, "R4 ack when empty");

    // R7: ports 1 and 3 race to port 0
    wr1(1, 1, 32'h0000_0022);
    wr1(3, 1, 32'h0000_0033);
    wr2(1, 0, 32'h0, 3, 0, 32'h0);
    rd(0, 2, 32'h0000_0022, "R7 lower port data");
    rd(0, 3, 32'h0000_0101, "R7 lower port sender");
    rd(3, 3, 32'h0000_0002, "R7 loser busy");
    rd(1, 3, 32'h0000_0000, "R7 winner not busy");

    // R6: retry success clears busy
    wr1(0, 4, 32'h0);
    wr1(3, 0, 32'h0000_0000);
    rd(3, 3, 32'h0000_0000, "R6 busy cleared by success");
    rd(0, 3, 32'h0000_0301, "R6 retry delivered sender");
    rd(0, 2, 32'h0000_0033, "R6 retry delivered data");

    // R8: self send
    wr1(3, 1, 32'h0000_0044);
    wr1(3, 0, 32'h0000_0003);
    rd(3, 2, 32'h0000_0044, "R8 self data");
    rd(3, 3, 32'h0000_0301, "R8 self status");
    irq_is(4'b1001, "R8 self irq");

    // R6: refusal coincident with the target's ack
    wr2(2, 0, 32'h0000_0003, 3, 4, 32'h0);
    rd(2, 3, 32'h0000_0002, "R6 coincident busy set");
    rd(3, 3, 32'h0000_0300, "R6 coincident ack done");
    wr1(2, 0, 32'h0000_0003);
    rd(2, 3, 32'h0000_0000, "R6 busy cleared on retry");
    rd(3, 2, 32'h0000_BEEF, "R6 retry data");
    rd(3, 3, 32'h0000_0201, "R6 retry sender");

    // R9: out-of-range target
    wr1(0, 4, 32'h0);
    wr1(0, 0, 32'h0000_0009);
    wr1(1, 0, 32'h0000_0004);
    irq_is(4'b1000, "R9 no new irq");
    rd(0, 3, 32'h0000_0300, "R9 no busy port0");
    rd(1, 3, 32'h0000_0000, "R9 no busy port1");

    // R10: write-only offsets read zero, reads have no effect
    rd(3, 0, 32'h0, "R10 offset0 reads 0");
    rd(3, 1, 32'h0, "R10 offset1 reads 0");
    rd(3, 4, 32'h0, "R10 offset4 reads 0");
    repeat (3) rd(3, 2, 32'h0000_BEEF, "R10 repeated read");
    irq_is(4'b1000, "R10 irq unaffected by reads");

    repeat (2) idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule